// File: doc/BRIEF.md
# DSP Index Address Generator

This block produces data memory addresses for a complex-arithmetic DSP core. It holds four pointer channels. Each channel has a pointer, a signed step, a base and a limit register, all 13 bits wide. Channel 0 addresses the constant ROM. Channels 1 to 3 address data RAM. A single 16-bit bias register lets RAM accesses be made relative to a movable window.

Each access request names a channel and an update mode. The block registers the effective address from the pointer value held before the request, and at the same clock edge it rewrites the pointer.

- **Wrap:** post-increment and post-decrement wrap by exact equality against the limit, which reloads the base.
- **Bit-reversed stepping:** steps are made in reversed bit order. A carry out of that reversed sum adds the limit register.
- **Bias:** a biased RAM access adds the sign-extended pointer, or a direct offset taken from the instruction, to the bias register.

Register fields are written and read through a simple select port.

Top module: `idx_addr_gen`

## Requirements
- R1: After synchronous reset every pointer, step, base, limit and the bias register are zero, `addr_valid` is 0 and `rd_data` is 0.
- R2: An access with `acc_valid`=1 gives `addr_valid`=1 one cycle later, and `addr_valid`=0 follows a cycle without an access. The address is the pointer value before this access's update, zero-extended to 16 bits. `addr_is_ram` is 1 exactly when `acc_chan` is not 0.
- R3: Mode code 1 (post-increment) sets a pointer that differs from its limit to pointer+step mod 2^13. Mode code 2 (post-decrement) sets it to pointer−step mod 2^13.
- R4: In mode 1 or 2, a pointer equal to its limit is reloaded with its base. A pointer that steps past the limit without equalling it keeps stepping; for example base 10, step 3, limit 22 visits 10, 13, 16, 19, 22, 10.
- R5: Mode code 3 on channels 1 to 3 computes S = rev(pointer) + rev(step) over 13 bits, with carry C out of bit 12. The new pointer is rev(S mod 2^13) + (C ? limit : 0) mod 2^13, where rev mirrors bit i to bit 12−i.
- R6: Mode code 0 leaves the pointer unchanged. On channel 0, mode code 3 also leaves the pointer unchanged.
- R7: With `acc_bias`=1 on channels 1 to 3, the address is bias + sign-extended 13-bit source mod 2^16. On channel 0, `acc_bias` has no effect.
- R8: With `acc_direct`=1, the source is `acc_offset` instead of the pointer, and no pointer changes.
- R9: A biased access with mode 1, 2 or 3 updates the unbiased pointer by the same rule as an unbiased access.
- R10: `wr_en` writes `wr_data` into the field chosen by `wr_sel` of channel `wr_chan`: 0 pointer, 1 step, 2 base, 3 limit. `bar_wr_en` writes the bias register. `rd_data` shows field `rd_sel` of channel `rd_chan` one cycle later, as held before that edge. An access in the same cycle uses the old field and bias values.
- R11: A pointer write and a pointer update to the same channel in one cycle leave the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request |
| acc_chan | input | 2 | Channel of the access |
| acc_mode | input | 2 | Update mode: 0 none, 1 increment, 2 decrement, 3 bit-reversed |
| acc_bias | input | 1 | Add bias register (RAM channels only) |
| acc_direct | input | 1 | Use acc_offset as source, no pointer update |
| acc_offset | input | 13 | Direct offset from the instruction |
| wr_en | input | 1 | Field write enable |
| wr_chan | input | 2 | Channel to write |
| wr_sel | input | 2 | Field to write: 0 pointer, 1 step, 2 base, 3 limit |
| wr_data | input | 13 | Field write value |
| bar_wr_en | input | 1 | Bias register write enable |
| bar_wr_data | input | 16 | Bias register write value |
| rd_chan | input | 2 | Channel to read |
| rd_sel | input | 2 | Field to read |
| rd_data | output | 13 | Registered read value |
| addr_valid | output | 1 | Registered address is valid |
| addr_is_ram | output | 1 | Registered address targets RAM (0 = ROM) |
| addr_out | output | 16 | Registered effective address |

## Verification
- **Wrap by equality:** a channel is set to base 10, step 3, limit 22 and must return to 10 after 22. A second channel steps past its limit and must never wrap. Together these separate equality matching from a greater-or-equal compare.
- **Bit-reversed stepping:** one case forces the reversed sum to carry out, so that adding the limit is visible. A long run of mixed modes, channels, biases, direct offsets, field writes and colliding pointer writes compares every output against a behavioural model on every clock.
- **Sign and region handling:** biased accesses with negative pointers and offsets check sign extension. Channel 0 with bias or mode 3 checks that ROM accesses ignore both.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2,
    UPD_BREV = 2'd3
  } upd_mode_t;

  typedef enum logic [1:0] {
    FLD_PTR  = 2'd0,
    FLD_STEP = 2'd1,
    FLD_BASE = 2'd2,
    FLD_LIM  = 2'd3
  } fld_sel_t;
endpackage

// File: rtl/agu_chan.sv
module agu_chan
  import agu_pkg::*;
#(
  parameter int PW       = 13,
  parameter bit HAS_BREV = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [1:0]    mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] inc_q,
  output logic [PW-1:0] base_q,
  output logic [PW-1:0] lim_q
);
  logic [PW-1:0] ptr_nx;
  logic [PW-1:0] brev_nx;
  logic          ptr_wr;
  upd_mode_t     md;

  assign md     = upd_mode_t'(mode);
  assign ptr_wr = wr_en && (wr_sel == FLD_PTR);

  generate
    if (HAS_BREV) begin : g_brev
      logic [PW-1:0] rev_ptr, rev_inc, rev_back;
      logic [PW:0]   rsum;
      for (genvar i = 0; i < PW; i++) begin : g_bit
        assign rev_ptr[i]  = ptr_q[PW-1-i];
        assign rev_inc[i]  = inc_q[PW-1-i];
        assign rev_back[i] = rsum[PW-1-i];
      end
      assign rsum    = {1'b0, rev_ptr} + {1'b0, rev_inc};
      assign brev_nx = rev_back + (rsum[PW] ? lim_q : '0);
    end else begin : g_nobrev
      assign brev_nx = ptr_q;
    end
  endgenerate

  always_comb begin
    case (md)
      UPD_INC:  ptr_nx = (ptr_q == lim_q) ? base_q : ptr_q + inc_q;
      UPD_DEC:  ptr_nx = (ptr_q == lim_q) ? base_q : ptr_q - inc_q;
      UPD_BREV: ptr_nx = brev_nx;
      default:  ptr_nx = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      inc_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
    end else begin
      if (ptr_wr)      ptr_q <= wr_data;
      else if (step)   ptr_q <= ptr_nx;
      if (wr_en && wr_sel == FLD_STEP) inc_q  <= wr_data;
      if (wr_en && wr_sel == FLD_BASE) base_q <= wr_data;
      if (wr_en && wr_sel == FLD_LIM)  lim_q  <= wr_data;
    end
  end

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> ptr_q == $past(wr_data));

  a_r4_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
    (step && !ptr_wr && (md == UPD_INC || md == UPD_DEC) && ptr_q == lim_q)
    |=> ptr_q == $past(base_q));

  a_r6_none_holds: assert property (@(posedge clk) disable iff (rst)
    (!ptr_wr && (!step || md == UPD_NONE)) |=> $stable(ptr_q));

  a_r10_limit_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == FLD_LIM) |=> lim_q == $past(wr_data));

  generate
    if (!HAS_BREV) begin : g_rom_chk
      a_r6_rom_brev_holds: assert property (@(posedge clk) disable iff (rst)
        (step && !ptr_wr && md == UPD_BREV) |=> $stable(ptr_q));
    end
  endgenerate
endmodule

// File: rtl/agu_addr_form.sv
module agu_addr_form #(
  parameter int PW = 13,
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [CW-1:0] acc_chan,
  input  logic          acc_bias,
  input  logic          acc_direct,
  input  logic [PW-1:0] acc_offset,
  input  logic [PW-1:0] sel_ptr,
  input  logic          bar_wr_en,
  input  logic [AW-1:0] bar_wr_data,
  output logic          addr_valid,
  output logic          addr_is_ram,
  output logic [AW-1:0] addr_out
);
  localparam int XW = AW - PW;

  logic [AW-1:0] bar_q;
  logic [PW-1:0] src;
  logic [AW-1:0] src_sx, src_zx, eff;
  logic          is_ram;

  assign is_ram = (acc_chan != '0);
  assign src    = acc_direct ? acc_offset : sel_ptr;
  assign src_sx = {{XW{src[PW-1]}}, src};
  assign src_zx = {{XW{1'b0}}, src};
  assign eff    = (is_ram && acc_bias) ? bar_q + src_sx : src_zx;

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_q       <= '0;
      addr_valid  <= 1'b0;
      addr_is_ram <= 1'b0;
      addr_out    <= '0;
    end else begin
      if (bar_wr_en) bar_q <= bar_wr_data;
      addr_valid <= acc_valid;
      if (acc_valid) begin
        addr_is_ram <= is_ram;
        addr_out    <= eff;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> addr_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !addr_valid);

  a_r7_rom_unbiased: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_is_ram) |-> addr_out[AW-1:PW] == '0);

  a_r10_bar_write: assert property (@(posedge clk) disable iff (rst)
    bar_wr_en |=> bar_q == $past(bar_wr_data));
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import agu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 13,
  parameter int AW  = 16,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [CW-1:0] acc_chan,
  input  logic [1:0]    acc_mode,
  input  logic          acc_bias,
  input  logic          acc_direct,
  input  logic [PW-1:0] acc_offset,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [1:0]    wr_sel,
  input  logic [PW-1:0] wr_data,
  input  logic          bar_wr_en,
  input  logic [AW-1:0] bar_wr_data,
  input  logic [CW-1:0] rd_chan,
  input  logic [1:0]    rd_sel,
  output logic [PW-1:0] rd_data,
  output logic          addr_valid,
  output logic          addr_is_ram,
  output logic [AW-1:0] addr_out
);
  logic [PW-1:0] ptr_all  [NCH];
  logic [PW-1:0] inc_all  [NCH];
  logic [PW-1:0] base_all [NCH];
  logic [PW-1:0] lim_all  [NCH];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic ch_step, ch_wr;
      assign ch_step = acc_valid && !acc_direct && (acc_chan == CW'(g));
      assign ch_wr   = wr_en && (wr_chan == CW'(g));
      agu_chan #(.PW(PW), .HAS_BREV(g != 0)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .step   (ch_step),
        .mode   (acc_mode),
        .wr_en  (ch_wr),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .ptr_q  (ptr_all[g]),
        .inc_q  (inc_all[g]),
        .base_q (base_all[g]),
        .lim_q  (lim_all[g])
      );
    end
  endgenerate

  agu_addr_form #(.PW(PW), .AW(AW), .CW(CW)) u_form (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_chan   (acc_chan),
    .acc_bias   (acc_bias),
    .acc_direct (acc_direct),
    .acc_offset (acc_offset),
    .sel_ptr    (ptr_all[acc_chan]),
    .bar_wr_en  (bar_wr_en),
    .bar_wr_data(bar_wr_data),
    .addr_valid (addr_valid),
    .addr_is_ram(addr_is_ram),
    .addr_out   (addr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (fld_sel_t'(rd_sel))
        FLD_PTR:  rd_data <= ptr_all[rd_chan];
        FLD_STEP: rd_data <= inc_all[rd_chan];
        FLD_BASE: rd_data <= base_all[rd_chan];
        default:  rd_data <= lim_all[rd_chan];
      endcase
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!addr_valid && rd_data == '0));
endmodule

// File: tb/idx_addr_gen_tb.sv
module idx_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 0, acc_bias = 0, acc_direct = 0;
  logic [1:0]  acc_chan = 0, acc_mode = 0;
  logic [12:0] acc_offset = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_chan = 0, wr_sel = 0;
  logic [12:0] wr_data = 0;
  logic        bar_wr_en = 0;
  logic [15:0] bar_wr_data = 0;
  logic [1:0]  rd_chan = 0, rd_sel = 0;
  logic [12:0] rd_data;
  logic        addr_valid, addr_is_ram;
  logic [15:0] addr_out;

  int n_chk = 0, n_fail = 0;
  int m_fld [4][4];
  int m_bar = 0;
  int e_valid = 0, e_ram = 0, e_addr = 0, e_rd = 0;

  always #4 clk = ~clk;

  idx_addr_gen u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_chan(acc_chan),
    .acc_mode(acc_mode), .acc_bias(acc_bias), .acc_direct(acc_direct),
    .acc_offset(acc_offset), .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel),
    .wr_data(wr_data), .bar_wr_en(bar_wr_en), .bar_wr_data(bar_wr_data),
    .rd_chan(rd_chan), .rd_sel(rd_sel), .rd_data(rd_data),
    .addr_valid(addr_valid), .addr_is_ram(addr_is_ram), .addr_out(addr_out)
  );

  function automatic int rev13(int v);
    int r = 0;
    for (int i = 0; i < 13; i++) if (((v >> i) & 1) == 1) r |= (1 << (12 - i));
    return r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int ch, src, s, x, n, sum, nx;
    e_rd = m_fld[rd_chan][rd_sel];
    e_valid = acc_valid ? 1 : 0;
    nx = 0;
    if (acc_valid) begin
      ch  = int'(acc_chan);
      src = acc_direct ? int'(acc_offset) : m_fld[ch][0];
      e_ram = (ch != 0) ? 1 : 0;
      if (ch != 0 && acc_bias) begin
        s = (src >= 4096) ? src - 8192 : src;
        e_addr = (m_bar + s) & 'hFFFF;
      end else e_addr = src;
      if (!acc_direct) begin
        x = m_fld[ch][0]; n = m_fld[ch][1];
        case (acc_mode)
          2'd1: nx = (x == m_fld[ch][3]) ? m_fld[ch][2] : (x + n) & 8191;
          2'd2: nx = (x == m_fld[ch][3]) ? m_fld[ch][2] : (x - n) & 8191;
          2'd3: begin
            if (ch == 0) nx = x;
            else begin
              sum = rev13(x) + rev13(n);
              nx = (rev13(sum & 8191) + (((sum >> 13) & 1) == 1 ? m_fld[ch][3] : 0)) & 8191;
            end
          end
          default: nx = x;
        endcase
        m_fld[ch][0] = nx;
      end
    end
    if (wr_en) m_fld[wr_chan][wr_sel] = int'(wr_data);
    if (bar_wr_en) m_bar = int'(bar_wr_data);
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, "addr_valid", int'(addr_valid), e_valid);
    if (e_valid == 1) begin
      check(tag, "addr_is_ram", int'(addr_is_ram), e_ram);
      check(tag, "addr_out", int'(addr_out), e_addr);
    end
    check(tag, "rd_data", int'(rd_data), e_rd);
  endtask

  task automatic idle();
    acc_valid = 0; acc_bias = 0; acc_direct = 0; wr_en = 0; bar_wr_en = 0;
  endtask

  task automatic wr(int ch, int sel, int val, string tag);
    idle(); wr_en = 1; wr_chan = 2'(ch); wr_sel = 2'(sel); wr_data = 13'(val);
    tick(tag); idle();
  endtask

  task automatic acc(int ch, int md, bit bias, bit dir, int off, string tag);
    idle(); acc_valid = 1; acc_chan = 2'(ch); acc_mode = 2'(md);
    acc_bias = bias; acc_direct = dir; acc_offset = 13'(off);
    tick(tag); idle();
  endtask

  task automatic rdchk(int ch, int sel, string tag);
    idle(); rd_chan = 2'(ch); rd_sel = 2'(sel); tick(tag);
  endtask

  task automatic setup(int ch, int p, int n, int b, int l, string tag);
    wr(ch, 1, n, tag); wr(ch, 2, b, tag); wr(ch, 3, l, tag); wr(ch, 0, p, tag);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    foreach (m_fld[i, j]) m_fld[i][j] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state of every field
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 4; f++) rdchk(c, f, "R1");

    // R10: field writes and readback
    setup(3, 10, 3, 10, 22, "R10");
    for (int f = 0; f < 4; f++) rdchk(3, f, "R10");

    // R4 / R2: wrap by equality 10,13,16,19,22,10
    for (int k = 0; k < 6; k++) acc(3, 1, 0, 0, 0, "R4");
    rdchk(3, 0, "R4");

    // R4: pass over limit, no wrap; R3 increment
    setup(2, 0, 4, 0, 6, "R3");
    for (int k = 0; k < 5; k++) acc(2, 1, 0, 0, 0, "R4");
    // R3: decrement with wrap
    setup(1, 20, 5, 20, 5, "R3");
    for (int k = 0; k < 6; k++) acc(1, 2, 0, 0, 0, "R3");

    // R5: bit-reversed counting, then forced carry adds limit
    setup(2, 0, 4096, 0, 100, "R5");
    for (int k = 0; k < 9; k++) acc(2, 3, 0, 0, 0, "R5");
    setup(2, 8191, 4096, 0, 100, "R5");
    acc(2, 3, 0, 0, 0, "R5");
    rdchk(2, 0, "R5");

    // R6: channel 0 ignores mode 3, mode 0 holds
    setup(0, 77, 5, 0, 200, "R6");
    acc(0, 3, 0, 0, 0, "R6");
    acc(0, 0, 0, 0, 0, "R6");
    rdchk(0, 0, "R6");
    acc(3, 0, 0, 0, 0, "R6");
    rdchk(3, 0, "R6");

    // R7: bias with negative pointer, channel 0 ignores bias
    idle(); bar_wr_en = 1; bar_wr_data = 16'h1000; tick("R7"); idle();
    wr(1, 0, 8190, "R7");
    acc(1, 0, 1, 0, 0, "R7");
    acc(0, 1, 1, 0, 0, "R7");

    // R8: direct offsets, pointer untouched
    acc(2, 1, 1, 1, 8191, "R8");
    acc(2, 1, 0, 1, 8191, "R8");
    acc(0, 1, 1, 1, 300, "R8");
    rdchk(2, 0, "R8");

    // R9: biased access updates unbiased pointer
    setup(3, 4, 2, 4, 8, "R9");
    for (int k = 0; k < 4; k++) acc(3, 1, 1, 0, 0, "R9");
    rdchk(3, 0, "R9");

    // R11: same-cycle write and update
    idle(); acc_valid = 1; acc_chan = 3; acc_mode = 1;
    wr_en = 1; wr_chan = 3; wr_sel = 0; wr_data = 13'd555;
    tick("R11"); idle();
    rdchk(3, 0, "R11");

    // R2: mixed random traffic compared every clock
    for (int k = 0; k < 3000; k++) begin
      acc_valid   = ($urandom % 4) != 0;
      acc_chan    = 2'($urandom);
      acc_mode    = 2'($urandom);
      acc_bias    = 1'($urandom);
      acc_direct  = ($urandom % 6) == 0;
      acc_offset  = 13'($urandom);
      wr_en       = ($urandom % 5) == 0;
      wr_chan     = 2'($urandom);
      wr_sel      = 2'($urandom);
      wr_data     = ($urandom % 3 == 0) ? 13'($urandom % 16) : 13'($urandom);
      bar_wr_en   = ($urandom % 20) == 0;
      bar_wr_data = 16'($urandom);
      rd_chan     = 2'($urandom);
      rd_sel      = 2'($urandom);
      tick("R2");
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule